// File: doc/BRIEF.md
# Processor run-control debug unit

This unit sits between a host command channel and a simple in-order core and decides, cycle by cycle, whether the core may retire an instruction. A host drives one-cycle commands with an opcode and a 32-bit argument. The commands start free running, halt the core, advance it by a counted number of instructions, redirect its program counter, arm or disarm one address breakpoint, and fetch register-file or memory words. Read results come back as a separate one-cycle response.

The core is seen only through a narrow interface. The unit receives its fetch PC, a retire strobe, a combinational register read port and a memory read port, and it returns a go/enable signal and a PC load strobe. Free-running cycle and retired-instruction counters are visible to the host. Messages that the core emits on retirement pass to the host through a bounded FIFO. When that FIFO is full the core is held, so elapsed cycles can run ahead of retired instructions.

Top module: `rcd_dbg_unit`

## Requirements
- R1: After reset the unit is halted: `halted`=1, `core_go`=0, both counters are 0, `msg_valid`=0 and `rsp_valid`=0.
- R2: Opcode 1 (start) makes the unit run from the next cycle, with `core_go`=1. Opcode 2 (stop) halts it from the next cycle. An instruction retires in the cycle that carries the stop command, and none retire after it.
- R3: Opcode 3 (step) with a nonzero argument N lets exactly N instructions retire and then returns to halted. An argument of 0 is ignored and the unit stays halted.
- R4: Opcode 4 (write PC) loads `cmd_arg` into the core through `core_pc_wr_en`/`core_pc_wr_data` in the same cycle, and only while halted. While running it is ignored. `pc_out` always shows the core's fetch PC.
- R5: Opcode 7 (register read, index in `cmd_arg[4:0]`) accepted while halted yields `rsp_valid`=1 one cycle later, with the register value on `rsp_data`. A request made while running is held and is answered one cycle after the unit halts.
- R6: Opcode 8 (memory read, address in `cmd_arg`) behaves like R5 and returns the memory word at that address.
- R7: `cyc_count` increments on every clock that the unit is not halted, including stalled clocks. `inst_count` increments once per retired instruction.
- R8: Opcode 5 arms the breakpoint at address `cmd_arg`, and opcode 6 disarms it. While the breakpoint is armed and the unit is not halted, a fetch PC equal to the breakpoint address drops `core_go` in that cycle and halts the unit, and the instruction at that address does not retire.
- R9: A start or step issued while halted on the breakpoint retires the instruction at the breakpoint address without stopping on it again.
- R10: A retirement with `core_msg_valid`=1 pushes `core_msg_data` into a 4-deep FIFO. The host receives the messages in order on `msg_data` while `msg_valid`=1, and each is consumed by `msg_ready`. While the FIFO is full `core_go` is 0 and `cyc_count` keeps advancing.
- R11: Only one read is outstanding at a time. A read command that arrives while another is pending is dropped and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | 32 | Command argument |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data |
| pc_out | output | 32 | Current fetch PC |
| cyc_count | output | 32 | Non-halted cycle counter |
| inst_count | output | 32 | Retired instruction counter |
| halted | output | 1 | Unit is halted |
| msg_valid | output | 1 | Host message available |
| msg_data | output | 32 | Head host message |
| msg_ready | input | 1 | Host consumes head message |
| core_fetch_pc | input | 32 | Core fetch PC |
| core_go | output | 1 | Core may retire this cycle |
| core_retired | input | 1 | Core retired an instruction |
| core_msg_valid | input | 1 | Retiring instruction carries a message |
| core_msg_data | input | 32 | Message payload |
| core_pc_wr_en | output | 1 | Load core PC |
| core_pc_wr_data | output | 32 | New core PC |
| core_rf_idx | output | 5 | Register read index |
| core_rf_data | input | 32 | Register read data |
| core_mem_addr | output | 32 | Memory read address |
| core_mem_data | input | 32 | Memory read data |

## Verification
The hardest situation to produce is the interplay of a full message FIFO with the run state. The core is running but retires nothing, and the cycle counter moves ahead while the instruction counter stands still. The stimulus holds `msg_ready` low while a core that emits a message on every instruction runs free until the FIFO fills. It then releases `msg_ready` and issues stop in the middle of the drain, and checks that every message arrives in PC order and that their count equals the retired count. Resuming from a breakpoint is the other awkward corner. It is reached by sweeping the breakpoint distance, halting on it, and then both stepping and restarting across the same address.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_START = 4'd1,
      OP_STOP  = 4'd2,
      OP_STEP  = 4'd3,
      OP_WRPC  = 4'd4,
      OP_SETBP = 4'd5,
      OP_CLRBP = 4'd6,
      OP_RDREG = 4'd7,
      OP_RDMEM = 4'd8
   } rcd_op_e;

   typedef enum logic [1:0] {
      ST_HALT = 2'd0,
      ST_RUN  = 2'd1,
      ST_STEP = 2'd2
   } rcd_state_e;

endpackage

// File: rtl/rcd_run_fsm.sv
module rcd_run_fsm
   import rcd_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int STEP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [XLEN-1:0]   cmd_arg,
   input  logic [XLEN-1:0]   fetch_pc,
   input  logic              retired,
   input  logic              fifo_full,
   output logic              core_go,
   output logic              halted,
   output logic              pc_wr_en,
   output logic [XLEN-1:0]   pc_wr_data,
   output rcd_state_e        state_o,
   output logic [STEP_W-1:0] step_cnt_o
);

   if (STEP_W < 1 || STEP_W > XLEN) begin : g_bad_step_w
      $error("rcd_run_fsm: STEP_W must lie in 1..XLEN");
   end

   rcd_state_e        state_q;
   logic [STEP_W-1:0] step_cnt_q;
   logic              bp_armed_q;
   logic [XLEN-1:0]   bp_addr_q;
   logic              bp_skip_q;

   logic is_start, is_stop, is_step, is_wrpc, is_setbp, is_clrbp;
   logic step_ok, bp_hit, active;

   always_comb begin
      is_start = cmd_valid && (cmd_op == OP_START);
      is_stop  = cmd_valid && (cmd_op == OP_STOP);
      is_step  = cmd_valid && (cmd_op == OP_STEP);
      is_wrpc  = cmd_valid && (cmd_op == OP_WRPC);
      is_setbp = cmd_valid && (cmd_op == OP_SETBP);
      is_clrbp = cmd_valid && (cmd_op == OP_CLRBP);
      step_ok  = is_step && (cmd_arg[STEP_W-1:0] != '0);
      active   = (state_q != ST_HALT);
      bp_hit   = bp_armed_q && (fetch_pc == bp_addr_q) && !bp_skip_q;
      core_go  = active && !fifo_full && !bp_hit;
      halted   = !active;
      pc_wr_en   = is_wrpc && !active;
      pc_wr_data = cmd_arg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_HALT;
         step_cnt_q <= '0;
      end else if (is_stop) begin
         state_q <= ST_HALT;
      end else if (step_ok) begin
         state_q    <= ST_STEP;
         step_cnt_q <= cmd_arg[STEP_W-1:0];
      end else if (is_start) begin
         state_q <= ST_RUN;
      end else if (active && bp_hit) begin
         state_q <= ST_HALT;
      end else if (state_q == ST_STEP && retired) begin
         step_cnt_q <= step_cnt_q - STEP_W'(1);
         if (step_cnt_q == STEP_W'(1)) begin
            state_q <= ST_HALT;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_armed_q <= 1'b0;
         bp_addr_q  <= '0;
      end else if (is_setbp) begin
         bp_armed_q <= 1'b1;
         bp_addr_q  <= cmd_arg;
      end else if (is_clrbp) begin
         bp_armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_skip_q <= 1'b0;
      end else if (!active && (is_start || step_ok)) begin
         bp_skip_q <= 1'b1;
      end else if (retired) begin
         bp_skip_q <= 1'b0;
      end
   end

   assign state_o    = state_q;
   assign step_cnt_o = step_cnt_q;

endmodule

// File: rtl/rcd_event_ctr.sv
module rcd_event_ctr #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = '1;

   if (W < 2) begin : g_bad_w
      $error("rcd_event_ctr: W must be at least 2");
   end

   logic [W-1:0] q_r;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_r <= '0;
         end else if (inc && (q_r != MAXV)) begin
            q_r <= q_r + W'(1);
         end
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_r <= '0;
         end else if (inc) begin
            q_r <= q_r + W'(1);
         end
      end
   end

   assign q = q_r;

endmodule

// File: rtl/rcd_msg_fifo.sv
module rcd_msg_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rcd_msg_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   level;
   logic          push_ok, pop_ok;

   always_comb begin
      full      = (level == (AW+1)'(DEPTH));
      out_valid = (level != '0);
      push_ok   = push && !full;
      pop_ok    = pop && out_valid;
      out_data  = store[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         store[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) begin
            wr_ptr <= wr_ptr + AW'(1);
         end
         if (pop_ok) begin
            rd_ptr <= rd_ptr + AW'(1);
         end
         case ({push_ok, pop_ok})
            2'b10:   level <= level + (AW+1)'(1);
            2'b01:   level <= level - (AW+1)'(1);
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/rcd_read_port.sv
module rcd_read_port
   import rcd_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [XLEN-1:0]  cmd_arg,
   input  logic             halted,
   output logic [IDX_W-1:0] rf_idx,
   input  logic [XLEN-1:0]  rf_data,
   output logic [XLEN-1:0]  mem_addr,
   input  logic [XLEN-1:0]  mem_data,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_data
);

   if (IDX_W < 1 || IDX_W > XLEN) begin : g_bad_idx_w
      $error("rcd_read_port: IDX_W must lie in 1..XLEN");
   end

   logic            pend_q;
   logic            pend_mem_q;
   logic [XLEN-1:0] pend_arg_q;
   logic            is_rd_reg, is_rd_mem, accept;

   always_comb begin
      is_rd_reg = cmd_valid && (cmd_op == OP_RDREG);
      is_rd_mem = cmd_valid && (cmd_op == OP_RDMEM);
      accept    = (is_rd_reg || is_rd_mem) && !pend_q;
      rf_idx    = pend_arg_q[IDX_W-1:0];
      mem_addr  = pend_arg_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_mem_q <= 1'b0;
         pend_arg_q <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (pend_q && halted) begin
            rsp_valid <= 1'b1;
            rsp_data  <= pend_mem_q ? mem_data : rf_data;
            pend_q    <= 1'b0;
         end else if (accept) begin
            pend_q     <= 1'b1;
            pend_mem_q <= is_rd_mem;
            pend_arg_q <= cmd_arg;
         end
      end
   end

endmodule

// File: rtl/rcd_dbg_unit.sv
module rcd_dbg_unit
   import rcd_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IDX_W      = 5,
   parameter int STEP_W     = 32,
   parameter int CNT_W      = 32,
   parameter int FIFO_DEPTH = 4,
   parameter bit CNT_SAT    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [XLEN-1:0]  cmd_arg,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_data,
   output logic [XLEN-1:0]  pc_out,
   output logic [CNT_W-1:0] cyc_count,
   output logic [CNT_W-1:0] inst_count,
   output logic             halted,
   output logic             msg_valid,
   output logic [XLEN-1:0]  msg_data,
   input  logic             msg_ready,
   input  logic [XLEN-1:0]  core_fetch_pc,
   output logic             core_go,
   input  logic             core_retired,
   input  logic             core_msg_valid,
   input  logic [XLEN-1:0]  core_msg_data,
   output logic             core_pc_wr_en,
   output logic [XLEN-1:0]  core_pc_wr_data,
   output logic [IDX_W-1:0] core_rf_idx,
   input  logic [XLEN-1:0]  core_rf_data,
   output logic [XLEN-1:0]  core_mem_addr,
   input  logic [XLEN-1:0]  core_mem_data
);

   if (XLEN < 8) begin : g_bad_xlen
      $error("rcd_dbg_unit: XLEN must be at least 8");
   end

   logic              fifo_full;
   logic              msg_push;
   rcd_state_e        fsm_state;
   logic [STEP_W-1:0] step_cnt;

   assign pc_out   = core_fetch_pc;
   assign msg_push = core_retired && core_msg_valid;

   rcd_run_fsm #(
      .XLEN   (XLEN),
      .STEP_W (STEP_W)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_arg    (cmd_arg),
      .fetch_pc   (core_fetch_pc),
      .retired    (core_retired),
      .fifo_full  (fifo_full),
      .core_go    (core_go),
      .halted     (halted),
      .pc_wr_en   (core_pc_wr_en),
      .pc_wr_data (core_pc_wr_data),
      .state_o    (fsm_state),
      .step_cnt_o (step_cnt)
   );

   rcd_event_ctr #(
      .W        (CNT_W),
      .SATURATE (CNT_SAT)
   ) i_cyc_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (!halted),
      .q     (cyc_count)
   );

   rcd_event_ctr #(
      .W        (CNT_W),
      .SATURATE (CNT_SAT)
   ) i_inst_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (core_retired),
      .q     (inst_count)
   );

   rcd_msg_fifo #(
      .W     (XLEN),
      .DEPTH (FIFO_DEPTH)
   ) i_msg_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (msg_push),
      .push_data (core_msg_data),
      .pop       (msg_ready),
      .out_valid (msg_valid),
      .out_data  (msg_data),
      .full      (fifo_full)
   );

   rcd_read_port #(
      .XLEN  (XLEN),
      .IDX_W (IDX_W)
   ) i_rd_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_arg   (cmd_arg),
      .halted    (halted),
      .rf_idx    (core_rf_idx),
      .rf_data   (core_rf_data),
      .mem_addr  (core_mem_addr),
      .mem_data  (core_mem_data),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

endmodule

// File: rtl/rcd_dbg_checker.sv
module rcd_dbg_checker
   import rcd_pkg::*;
#(
   parameter int STEP_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              halted,
   input logic              core_go,
   input logic              core_retired,
   input logic              core_pc_wr_en,
   input logic              rsp_valid,
   input logic              fifo_full,
   input logic [CNT_W-1:0]  cyc_count,
   input logic [CNT_W-1:0]  inst_count,
   input rcd_state_e        fsm_state,
   input logic [STEP_W-1:0] step_cnt
);

   AST_HALT_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !core_go); // R2

   AST_FULL_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !core_go); // R10

   AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(cyc_count)); // R7

   AST_INST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_retired && inst_count != '1) |=> (inst_count == $past(inst_count) + CNT_W'(1))); // R7

   AST_PCWR_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      core_pc_wr_en |-> halted); // R4

   AST_RSP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(halted)); // R5

   AST_STEP_END: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_STEP && step_cnt == STEP_W'(1) && core_retired && !cmd_valid) |=> halted); // R3

endmodule

bind rcd_dbg_unit rcd_dbg_checker #(
   .STEP_W (STEP_W),
   .CNT_W  (CNT_W)
) i_rcd_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .halted        (halted),
   .core_go       (core_go),
   .core_retired  (core_retired),
   .core_pc_wr_en (core_pc_wr_en),
   .rsp_valid     (rsp_valid),
   .fifo_full     (fifo_full),
   .cyc_count     (cyc_count),
   .inst_count    (inst_count),
   .fsm_state     (fsm_state),
   .step_cnt      (step_cnt)
);

// File: tb/test_rcd_dbg_unit.sv
module test_rcd_dbg_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'd0;
   logic [31:0] cmd_arg = 32'd0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic [31:0] pc_out;
   logic [31:0] cyc_count, inst_count;
   logic        halted;
   logic        msg_valid;
   logic [31:0] msg_data;
   logic        msg_ready = 1'b0;
   logic [31:0] core_fetch_pc;
   logic        core_go;
   logic        core_retired;
   logic        core_msg_valid;
   logic [31:0] core_msg_data;
   logic        core_pc_wr_en;
   logic [31:0] core_pc_wr_data;
   logic [4:0]  core_rf_idx;
   logic [31:0] core_rf_data;
   logic [31:0] core_mem_addr;
   logic [31:0] core_mem_data;

   logic        core_busy = 1'b0;
   logic        msg_en = 1'b0;
   logic [31:0] pc_q;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   localparam logic [31:0] MSG_KEY = 32'h5A00_0000;

   always #10 clk = ~clk;

   function automatic logic [31:0] rf_val(input logic [4:0] idx);
      return ({27'd0, idx} * 32'h0102_0304) + 32'h11;
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return ~a ^ {a[15:0], a[31:16]};
   endfunction

   // core model
   assign core_fetch_pc  = pc_q;
   assign core_retired   = core_go && !core_busy;
   assign core_msg_valid = msg_en;
   assign core_msg_data  = pc_q ^ MSG_KEY;
   assign core_rf_data   = rf_val(core_rf_idx);
   assign core_mem_data  = mem_val(core_mem_addr);

   always_ff @(posedge clk) begin
      if (!rst_n)              pc_q <= 32'h100;
      else if (core_pc_wr_en)  pc_q <= core_pc_wr_data;
      else if (core_retired)   pc_q <= pc_q + 32'd4;
   end

   rcd_dbg_unit i_rcd_dbg_unit (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pc_out(pc_out), .cyc_count(cyc_count), .inst_count(inst_count),
      .halted(halted),
      .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
      .core_fetch_pc(core_fetch_pc), .core_go(core_go), .core_retired(core_retired),
      .core_msg_valid(core_msg_valid), .core_msg_data(core_msg_data),
      .core_pc_wr_en(core_pc_wr_en), .core_pc_wr_data(core_pc_wr_data),
      .core_rf_idx(core_rf_idx), .core_rf_data(core_rf_data),
      .core_mem_addr(core_mem_addr), .core_mem_data(core_mem_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a negedge; the command is sampled at the following posedge
   task automatic send(input logic [3:0] op, input logic [31:0] arg);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_arg   = arg;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 4'd0;
      cmd_arg   = 32'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] c0, i0, p0, bpa;
      int          j;
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 halted", {31'd0, halted}, 32'd1);
      chk("R1 core_go", {31'd0, core_go}, 32'd0);
      chk("R1 cyc", cyc_count, 32'd0);
      chk("R1 inst", inst_count, 32'd0);
      chk("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

      // R2 start / stop
      c0 = cyc_count; i0 = inst_count; p0 = pc_out;
      send(4'd1, 32'd0);
      chk("R2 running", {31'd0, halted}, 32'd0);
      chk("R2 go", {31'd0, core_go}, 32'd1);
      tick(5);
      send(4'd2, 32'd0);
      chk("R2 halted after stop", {31'd0, halted}, 32'd1);
      chk("R2 inst", inst_count - i0, 32'd6);
      chk("R2 pc", pc_out, p0 + 32'd24);
      chk("R7 cyc running", cyc_count - c0, 32'd6);
      tick(3);
      chk("R2 pc frozen", pc_out, p0 + 32'd24);
      chk("R7 cyc frozen", cyc_count - c0, 32'd6);

      // R3 step sweep
      for (int n = 0; n <= 12; n++) begin
         c0 = cyc_count; i0 = inst_count; p0 = pc_out;
         send(4'd3, n);
         tick(n + 3);
         chk($sformatf("R3 step %0d inst", n), inst_count - i0, n);
         chk($sformatf("R3 step %0d pc", n), pc_out, p0 + 32'(4 * n));
         chk($sformatf("R7 step %0d cyc", n), cyc_count - c0, n);
         chk($sformatf("R3 step %0d halted", n), {31'd0, halted}, 32'd1);
      end

      // R4 write PC
      send(4'd4, 32'h2000);
      chk("R4 pc write halted", pc_out, 32'h2000);
      send(4'd1, 32'd0);
      send(4'd4, 32'h9000);
      send(4'd2, 32'd0);
      chk("R4 pc write ignored running", pc_out, 32'h2008);

      // R5 register reads, all indices
      for (int r = 0; r < 32; r++) begin
         send(4'd7, r);
         chk("R5 no early rsp", {31'd0, rsp_valid}, 32'd0);
         tick(1);
         chk($sformatf("R5 rsp_valid reg %0d", r), {31'd0, rsp_valid}, 32'd1);
         chk($sformatf("R5 data reg %0d", r), rsp_data, rf_val(r[4:0]));
         tick(1);
      end

      // R6 memory reads
      for (int a = 0; a < 16; a++) begin
         p0 = 32'h1234_0000 + 32'(a * 32'h44) ^ 32'(a << 20);
         send(4'd8, p0);
         tick(1);
         chk("R6 rsp_valid", {31'd0, rsp_valid}, 32'd1);
         chk($sformatf("R6 data addr %h", p0), rsp_data, mem_val(p0));
         tick(1);
      end

      // R5 read held while running, R11 second read dropped
      send(4'd1, 32'd0);
      send(4'd7, 32'd3);
      send(4'd7, 32'd9);
      for (int k = 0; k < 4; k++) begin
         chk("R5 held while running", {31'd0, rsp_valid}, 32'd0);
         tick(1);
      end
      send(4'd2, 32'd0);
      chk("R5 not yet at stop", {31'd0, rsp_valid}, 32'd0);
      tick(1);
      chk("R5 rsp after halt", {31'd0, rsp_valid}, 32'd1);
      chk("R11 first read wins", rsp_data, rf_val(5'd3));
      for (int k = 0; k < 4; k++) begin
         tick(1);
         chk("R11 no second rsp", {31'd0, rsp_valid}, 32'd0);
      end

      // R8 / R9 breakpoint distance sweep
      for (int d = 1; d <= 6; d++) begin
         send(4'd4, 32'h3000);
         bpa = 32'h3000 + 32'(4 * d);
         send(4'd5, bpa);
         c0 = cyc_count; i0 = inst_count;
         send(4'd1, 32'd0);
         tick(d + 4);
         chk($sformatf("R8 bp %0d halted", d), {31'd0, halted}, 32'd1);
         chk($sformatf("R8 bp %0d pc", d), pc_out, bpa);
         chk($sformatf("R8 bp %0d inst", d), inst_count - i0, d);
         chk($sformatf("R8 bp %0d cyc", d), cyc_count - c0, d + 1);
         i0 = inst_count;
         send(4'd3, 32'd1);
         tick(3);
         chk($sformatf("R9 step off bp %0d", d), pc_out, bpa + 32'd4);
         chk($sformatf("R9 step inst %0d", d), inst_count - i0, 32'd1);
         send(4'd4, bpa);
         send(4'd1, 32'd0);
         tick(2);
         send(4'd2, 32'd0);
         chk($sformatf("R9 start off bp %0d", d), pc_out, bpa + 32'd12);
      end
      send(4'd6, 32'd0);
      send(4'd4, 32'h3000);
      send(4'd1, 32'd0);
      tick(8);
      send(4'd2, 32'd0);
      chk("R8 disarmed", pc_out, 32'h3000 + 32'd36);

      // R7 stalled core: cycles advance, instructions do not
      core_busy = 1'b1;
      c0 = cyc_count; i0 = inst_count;
      send(4'd1, 32'd0);
      tick(5);
      send(4'd2, 32'd0);
      core_busy = 1'b0;
      chk("R7 busy cyc", cyc_count - c0, 32'd6);
      chk("R7 busy inst", inst_count - i0, 32'd0);

      // R10 message FIFO fill, stall, ordered drain
      send(4'd4, 32'h4000);
      msg_en = 1'b1;
      c0 = cyc_count; i0 = inst_count;
      send(4'd1, 32'd0);
      tick(10);
      chk("R10 full stalls inst", inst_count - i0, 32'd4);
      chk("R10 cyc advances", cyc_count - c0, 32'd10);
      chk("R10 go low when full", {31'd0, core_go}, 32'd0);
      chk("R10 msg_valid", {31'd0, msg_valid}, 32'd1);
      msg_ready = 1'b1;
      j = 0;
      for (int k = 0; k < 30; k++) begin
         if (msg_valid) begin
            chk($sformatf("R10 msg %0d", j), msg_data, (32'h4000 + 32'(4 * j)) ^ MSG_KEY);
            j++;
         end
         if (k == 8) begin
            cmd_valid = 1'b1; cmd_op = 4'd2; cmd_arg = 32'd0;
         end
         @(negedge clk);
         if (k == 8) begin
            cmd_valid = 1'b0; cmd_op = 4'd0;
            msg_en = 1'b0;
         end
      end
      msg_ready = 1'b0;
      chk("R10 all messages delivered", j, inst_count - i0);
      chk("R10 cyc exceeds inst", {31'd0, (cyc_count - c0) > (inst_count - i0)}, 32'd1);
      chk("R10 drained", {31'd0, msg_valid}, 32'd0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule